// File: doc/BRIEF.md
# Regulator Control Register Port (I2C Slave)

This block is the serial control port of a voltage regulator controller. An external host reaches a small set of byte-wide registers over a two-wire I2C bus. Through them it sets the output voltage code, a ceiling code that can be locked, the power state and the slew step. It can also read the load-current telemetry byte, the fault byte and four fixed lot-code bytes. The slave runs from the core clock. It oversamples the filtered SCL and SDA inputs and answers on SDA through an open-drain pull-down. The port is live whatever state the regulator enable is in.

Only two transaction shapes are served. A byte write is device address, register index, one data byte. A byte read is device address, register index, repeated START, device address with read bit, one data byte, then master NAK and STOP. Every write is checked against the rules of its target register. A write that breaks those rules gets a NAK on its data byte and leaves the register untouched. A register index outside the implemented set gets a NAK on the index byte.

Top module: `vreg_i2c_regs`

## Requirements
- R1: The slave acknowledges a device address whose upper four bits are 4'b1000 and whose lower three bits equal `addr_strap` as sampled during reset. Any other address is not acknowledged, and the transaction that follows is ignored until the next START.
- R2: In a valid byte write, the address, index and data bytes are each acknowledged by a low SDA during the ninth clock. The data byte takes effect on the register output by the end of that acknowledge slot.
- R3: A register index other than 0x00, 0x03, 0x04, 0x06, 0x07, 0x10–0x13 or 0x14 is not acknowledged, whether the transaction is a read or a write.
- R4: Register 0x00 (voltage code) resets to 0x48. It accepts data from 0x19 to 0x7F. Any other value is NAKed and the register keeps its value.
- R5: Register 0x04 (ceiling) resets to 0x67. Bits 6:0 hold the ceiling code and bit 7 is a lock. While the lock is set, every write is NAKed and the register is frozen. Only reset clears the lock.
- R6: Register 0x06 (power state) resets to 0x00 and accepts only 0, 1 or 2. A larger value is NAKed and does not change the register.
- R7: Register 0x07 (slew step) resets to the parameter value 0x01. It accepts only data with exactly one bit set. Zero or several set bits are NAKed and do not change the register.
- R8: Registers 0x03 (reads `imon_val`), 0x14 (reads `fault_val`) and 0x10–0x13 (read byte k of the lot-code parameter, byte 0 least significant, at 0x10+k) are read-only. Reads return those values MSB first. A write is NAKed at the data byte.
- R9: After the data byte of a write, any further byte is not acknowledged and is not stored. A STOP returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the bus |
| rst_n | input | 1 | Active-low supply-undervoltage reset |
| addr_strap | input | 3 | Low device address bits, sampled during reset |
| scl_in | input | 1 | Filtered SCL |
| sda_in | input | 1 | Filtered SDA (wired-AND bus level) |
| imon_val | input | 8 | Current telemetry byte |
| fault_val | input | 8 | Fault status byte |
| sda_pull | output | 1 | Pulls SDA low when high |
| vsel_q | output | 8 | Voltage code register |
| ceil_q | output | 8 | Ceiling register with lock in bit 7 |
| pstate_q | output | 8 | Power state register |
| slew_q | output | 8 | One-hot slew step register |

## Verification
The lock of the ceiling register is the hardest state to show. Once it is set, only a reset removes it, so the bench must prove two things. First, locked writes are refused both when they try to clear bit 7 and when they change the code. Second, the freeze lifts after reset and nothing else. The stimulus table sets the lock partway through and then attempts both kinds of locked write. The directed tail pulses reset with a new strap value. It then confirms three things: the ceiling returns to its reset code, a write is accepted again, and the slave now answers the newly strapped address.

// File: rtl/vreg_i2c_regs.sv
module vreg_i2c_regs #(
  parameter logic [7:0]  VSEL_RESET = 8'h48,
  parameter logic [7:0]  VSEL_MIN   = 8'h19,
  parameter logic [7:0]  CEIL_RESET = 8'h67,
  parameter logic [7:0]  SLEW_RESET = 8'h01,
  parameter logic [7:0]  PSTATE_MAX = 8'h02,
  parameter logic [31:0] LOT_CODE   = 32'hC0DE1234
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr_strap,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [7:0] imon_val,
  input  logic [7:0] fault_val,
  output logic       sda_pull,
  output logic [7:0] vsel_q,
  output logic [7:0] ceil_q,
  output logic [7:0] pstate_q,
  output logic [7:0] slew_q
);
  localparam logic [3:0] DEV_HI = 4'b1000;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_REG, S_WDATA, S_RDATA, S_SKIP} st_t;
  st_t state;

  logic [2:0] scl_r, sda_r;
  logic [7:0] shreg, ptr, rd_data;
  logic [3:0] bitcnt;
  logic [2:0] strap_q;
  logic       in_ack, rw, wr_ok;

  wire scl_rise = scl_r[1] & ~scl_r[2];
  wire scl_fall = ~scl_r[1] & scl_r[2];
  wire start_c  = scl_r[1] & scl_r[2] & sda_r[2] & ~sda_r[1];
  wire stop_c   = scl_r[1] & scl_r[2] & ~sda_r[2] & sda_r[1];
  wire addr_hit = (shreg[7:1] == {DEV_HI, strap_q});
  wire rx_state = (state == S_ADDR) || (state == S_REG) || (state == S_WDATA);

  function automatic logic is_reg(input logic [7:0] a);
    case (a)
      8'h00, 8'h03, 8'h04, 8'h06, 8'h07,
      8'h10, 8'h11, 8'h12, 8'h13, 8'h14: is_reg = 1'b1;
      default:                           is_reg = 1'b0;
    endcase
  endfunction

  always_comb begin
    case (ptr)
      8'h00:   rd_data = vsel_q;
      8'h03:   rd_data = imon_val;
      8'h04:   rd_data = ceil_q;
      8'h06:   rd_data = pstate_q;
      8'h07:   rd_data = slew_q;
      8'h10:   rd_data = LOT_CODE[7:0];
      8'h11:   rd_data = LOT_CODE[15:8];
      8'h12:   rd_data = LOT_CODE[23:16];
      8'h13:   rd_data = LOT_CODE[31:24];
      8'h14:   rd_data = fault_val;
      default: rd_data = 8'h00;
    endcase
  end

  always_comb begin
    case (ptr)
      8'h00:   wr_ok = (shreg >= VSEL_MIN) && !shreg[7];
      8'h04:   wr_ok = !ceil_q[7];
      8'h06:   wr_ok = (shreg <= PSTATE_MAX);
      8'h07:   wr_ok = (shreg != 8'h00) && ((shreg & (shreg - 8'd1)) == 8'h00);
      default: wr_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_r    <= 3'b111;
      sda_r    <= 3'b111;
      state    <= S_IDLE;
      shreg    <= 8'h00;
      ptr      <= 8'h00;
      bitcnt   <= 4'd0;
      in_ack   <= 1'b0;
      rw       <= 1'b0;
      sda_pull <= 1'b0;
      strap_q  <= addr_strap;
      vsel_q   <= VSEL_RESET;
      ceil_q   <= CEIL_RESET;
      pstate_q <= 8'h00;
      slew_q   <= SLEW_RESET;
    end else begin
      scl_r <= {scl_r[1:0], scl_in};
      sda_r <= {sda_r[1:0], sda_in};
      if (start_c) begin
        state    <= S_ADDR;
        bitcnt   <= 4'd0;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        state    <= S_IDLE;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (rx_state) begin
        if (scl_rise && !in_ack) begin
          shreg  <= {shreg[6:0], sda_r[1]};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && !in_ack && bitcnt == 4'd8) begin
          in_ack <= 1'b1;
          bitcnt <= 4'd0;
          if (state == S_ADDR) begin
            sda_pull <= addr_hit;
            rw       <= shreg[0];
          end else if (state == S_REG) begin
            sda_pull <= is_reg(shreg);
            if (is_reg(shreg)) ptr <= shreg;
          end else begin
            sda_pull <= wr_ok;
            if (wr_ok) begin
              case (ptr)
                8'h00:   vsel_q   <= shreg;
                8'h04:   ceil_q   <= shreg;
                8'h06:   pstate_q <= shreg;
                8'h07:   slew_q   <= shreg;
                default: ;
              endcase
            end
          end
        end else if (scl_fall && in_ack) begin
          in_ack   <= 1'b0;
          sda_pull <= 1'b0;
          if (!sda_pull || state == S_WDATA) begin
            state <= S_SKIP;
          end else if (state == S_REG) begin
            state <= S_WDATA;
          end else if (rw) begin
            state    <= S_RDATA;
            shreg    <= rd_data;
            sda_pull <= ~rd_data[7];
          end else begin
            state <= S_REG;
          end
        end
      end else if (state == S_RDATA) begin
        if (scl_rise) begin
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && bitcnt == 4'd8) begin
          sda_pull <= 1'b0;
          state    <= S_SKIP;
        end else if (scl_fall && bitcnt != 4'd0) begin
          shreg    <= {shreg[6:0], 1'b0};
          sda_pull <= ~shreg[6];
        end
      end
    end
  end
endmodule

// File: rtl/vreg_i2c_regs_chk.sv
module vreg_i2c_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_pull,
  input logic [7:0] vsel_q,
  input logic [7:0] ceil_q,
  input logic [7:0] pstate_q,
  input logic [7:0] slew_q
);
  p_ack_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_in);

  p_vsel_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vsel_q >= 8'h19) && !vsel_q[7]);

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ceil_q[7] |=> $stable(ceil_q));

  p_pstate_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pstate_q <= 8'h02);

  p_slew_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(slew_q));
endmodule

bind vreg_i2c_regs vreg_i2c_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_pull(sda_pull),
  .vsel_q(vsel_q), .ceil_q(ceil_q), .pstate_q(pstate_q), .slew_q(slew_q)
);

// File: tb/vreg_i2c_regs_tb_top.sv
`timescale 1ns/1ps
module vreg_i2c_regs_tb_top;
  localparam int Q = 8;
  localparam logic [31:0] LOT = 32'hC0DE1234;
  localparam int NV = 18;
  // {register, data, expected data ack, expected readback}
  localparam logic [24:0] VEC [NV] = '{
    {8'h00, 8'h5A, 1'b1, 8'h5A}, {8'h00, 8'h18, 1'b0, 8'h5A},
    {8'h00, 8'h19, 1'b1, 8'h19}, {8'h00, 8'h80, 1'b0, 8'h19},
    {8'h06, 8'h02, 1'b1, 8'h02}, {8'h06, 8'h03, 1'b0, 8'h02},
    {8'h06, 8'h00, 1'b1, 8'h00}, {8'h07, 8'h40, 1'b1, 8'h40},
    {8'h07, 8'h41, 1'b0, 8'h40}, {8'h07, 8'h00, 1'b0, 8'h40},
    {8'h04, 8'h55, 1'b1, 8'h55}, {8'h04, 8'hD0, 1'b1, 8'hD0},
    {8'h04, 8'h22, 1'b0, 8'hD0}, {8'h04, 8'h50, 1'b0, 8'hD0},
    {8'h03, 8'h77, 1'b0, 8'hA5}, {8'h14, 8'h12, 1'b0, 8'h3C},
    {8'h10, 8'h00, 1'b0, 8'h34}, {8'h13, 8'h00, 1'b0, 8'hC0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] strap = 3'b010;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] imon = 8'hA5, fault = 8'h3C;
  logic sda_pull;
  logic [7:0] vsel, ceil, pst, slew;
  wire sda_line = sda_m & ~sda_pull;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  vreg_i2c_regs #(.LOT_CODE(LOT)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_strap(strap), .scl_in(scl_m), .sda_in(sda_line),
    .imon_val(imon), .fault_val(fault), .sda_pull(sda_pull),
    .vsel_q(vsel), .ceil_q(ceil), .pstate_q(pst), .slew_q(slew));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = !sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic wr(input logic [6:0] dev, input logic [7:0] rg, input logic [7:0] d,
                    output logic a0, output logic a1, output logic a2);
    i2c_start();
    send_byte({dev, 1'b0}, a0);
    send_byte(rg, a1);
    send_byte(d, a2);
    i2c_stop();
  endtask

  task automatic rd(input logic [6:0] dev, input logic [7:0] rg, output logic [7:0] d,
                    output logic a0, output logic a1, output logic a2);
    i2c_start();
    send_byte({dev, 1'b0}, a0);
    send_byte(rg, a1);
    i2c_start();
    send_byte({dev, 1'b1}, a2);
    recv_byte(d);
    i2c_stop();
  endtask

  function automatic string tag_of(input logic [7:0] rg);
    case (rg)
      8'h00:   tag_of = "R4";
      8'h04:   tag_of = "R5";
      8'h06:   tag_of = "R6";
      8'h07:   tag_of = "R7";
      default: tag_of = "R8";
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic a0, a1, a2;
    logic [7:0] d;
    tick(5); rst_n = 1'b1; tick(5);

    check("R4 reset vsel", vsel, 8'h48);
    check("R5 reset ceil", ceil, 8'h67);
    check("R6 reset pstate", pst, 8'h00);
    check("R7 reset slew", slew, 8'h01);
    check("R2 idle no pull", {7'd0, sda_pull}, 8'h00);

    rd(7'h42, 8'h00, d, a0, a1, a2);
    check("R1 read acks", {5'd0, a0, a1, a2}, 8'h07);
    check("R4 read reset value", d, 8'h48);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] rg, dat, rb;
      logic ak;
      {rg, dat, ak, rb} = VEC[v];
      wr(7'h42, rg, dat, a0, a1, a2);
      check("R2 addr/index acks", {6'd0, a0, a1}, 8'h03);
      check(tag_of(rg), {7'd0, a2}, {7'd0, ak});
      rd(7'h42, rg, d, a0, a1, a2);
      check(tag_of(rg), d, rb);
    end

    wr(7'h42, 8'h05, 8'h30, a0, a1, a2);
    check("R3 write bad index", {6'd0, a0, a1}, 8'h02);
    rd(7'h42, 8'h15, d, a0, a1, a2);
    check("R3 read bad index", {7'd0, a1}, 8'h00);

    wr(7'h43, 8'h00, 8'h30, a0, a1, a2);
    check("R1 foreign address nak", {5'd0, a0, a1, a2}, 8'h00);
    check("R1 foreign write ignored", vsel, 8'h19);

    i2c_start();
    send_byte({7'h42, 1'b0}, a0);
    send_byte(8'h06, a1);
    send_byte(8'h01, a2);
    check("R9 data byte acked", {7'd0, a2}, 8'h01);
    send_byte(8'h02, a2);
    i2c_stop();
    check("R9 extra byte nak", {7'd0, a2}, 8'h00);
    check("R9 extra byte not stored", pst, 8'h01);

    strap = 3'b111;
    wr(7'h42, 8'h07, 8'h08, a0, a1, a2);
    check("R1 strap held since reset", {5'd0, a0, a1, a2}, 8'h07);
    check("R7 port value", slew, 8'h08);

    rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
    check("R5 lock cleared by reset", ceil, 8'h67);
    check("R4 vsel after reset", vsel, 8'h48);
    wr(7'h47, 8'h04, 8'h11, a0, a1, a2);
    check("R1 new strap address", {7'd0, a0}, 8'h01);
    check("R5 write after unlock", {7'd0, a2}, 8'h01);
    check("R5 ceil port", ceil, 8'h11);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule